// File: doc/BRIEF.md
# Address-Commanded Single-Precision Arithmetic Unit

This block is a bus slave holding eight single-precision (IEEE-754 binary32) registers. A host drives a 5-bit address, and the upper two address bits choose what a write does to the register picked by the lower three bits. The write can store the data word as is, add it to the register, subtract it from the register, or multiply the register by it. The result always replaces the register. Each bus write therefore carries a whole instruction together with its operand, and no separate command register exists.

Arithmetic uses round-to-nearest, ties-to-even. Subnormal values are treated as zero on input and flushed to zero on output. Overflow saturates to infinity. Every invalid case yields one canonical quiet NaN. An arithmetic write holds `ready` low for a fixed number of cycles while the result is formed. Any access presented during that window waits, so the next access always sees the finished result. Reads are registered: the data appears one cycle after the read is accepted.

Top module: `fp_addr_unit`

## Requirements
- R1: A write accepted at an address with bits [4:3] = 00 stores the data word unchanged into register addr[2:0].
- R2: A write accepted with addr[4:3] = 01 replaces register addr[2:0] with the register plus the written value.
- R3: A write accepted with addr[4:3] = 10 replaces register addr[2:0] with the register minus the written value.
- R4: A write accepted with addr[4:3] = 11 replaces register addr[2:0] with the register times the written value.
- R5: Sums, differences and products are rounded to nearest, with an exact tie going to the even significand (for example, 0x3F800001 + 0x33800000 gives 0x3F800002, and 0x3F800000 + 0x33800000 gives 0x3F800000).
- R6: An operand with exponent field 0 acts as a signed zero. A result whose exponent would fall below 1 before rounding becomes zero with the correct sign (0x00000000 or 0x80000000).
- R7: A finite result too large for binary32 becomes infinity with the sign of the true result (0x7F800000 or 0xFF800000).
- R8: A NaN operand, infinity minus infinity (after the effective sign is applied), and zero times infinity all produce exactly 0x7FC00000.
- R9: After an accepted arithmetic write, `ready` is low for exactly STALL cycles. An access presented while `ready` is low takes effect only once `ready` is high, so a read made during the stall returns the updated register.
- R10: A read accepted at any address returns register addr[2:0] on `rdata` in the next cycle. `rdata` holds its value in cycles with no accepted read.
- R11: Reset clears all eight registers to +0.0 (0x00000000) and leaves `ready` high.
- R12: Adding or subtracting operands that cancel exactly gives +0.0 (0x00000000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Operation in bits [4:3], register index in bits [2:0] |
| wdata | input | 32 | Write operand, binary32 |
| wr | input | 1 | Write strobe, taken when ready is high |
| rd | input | 1 | Read strobe, taken when ready is high |
| rdata | output | 32 | Register read result, valid the cycle after an accepted read |
| ready | output | 1 | High when the unit can accept an access |

## Verification
A corrupted register shows up on the next read of that register, one cycle after the read is accepted. It also spreads into every later arithmetic result that uses that register as its accumulator. A wrong stall counter shows up at once on `ready`: either the stall is too short, so a read that should wait returns the stale pre-operation value, or `ready` fails to return at all. Rounding and special-value faults stay hidden until a vector hits them, so the vectors target ties, cancellation, overflow, underflow and each NaN source on its own.

// File: rtl/fpu_pkg.sv
package fpu_pkg;

    localparam int          WORD_W = 32;
    localparam logic [31:0] QNAN   = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_MUL  = 2'b11
    } op_e;

    typedef struct packed {
        logic       sign;
        logic [7:0] exp;
        logic [22:0] frac;
    } f32_t;

    function automatic logic is_zero(f32_t x);
        return x.exp == 8'h00;
    endfunction

    function automatic logic is_inf(f32_t x);
        return (x.exp == 8'hFF) && (x.frac == 23'd0);
    endfunction

    function automatic logic is_nan(f32_t x);
        return (x.exp == 8'hFF) && (x.frac != 23'd0);
    endfunction

    // Round a normalised 24-bit significand (hidden bit at [23]) to nearest-even,
    // then saturate or flush according to the final exponent.
    function automatic f32_t pack_round(logic sgn, logic signed [9:0] e,
                                        logic [23:0] mant, logic g, logic st);
        logic        up;
        logic [24:0] m1;
        logic signed [9:0] e2;
        f32_t        r;
        up = g & (st | mant[0]);
        m1 = {1'b0, mant} + {24'd0, up};
        e2 = m1[24] ? e + 10'sd1 : e;
        if (e <= 10'sd0)
            r = {sgn, 31'd0};
        else if (e2 >= 10'sd255)
            r = {sgn, 8'hFF, 23'd0};
        else
            r = {sgn, e2[7:0], (m1[24] ? m1[23:1] : m1[22:0])};
        return r;
    endfunction

endpackage

// File: rtl/fpu_addsub.sv
module fpu_addsub
    import fpu_pkg::*;
(
    input  f32_t a,
    input  f32_t b,
    input  logic sub,
    output f32_t y
);
    logic        sa, sb, sbig;
    logic        a_big;
    logic [7:0]  ebig, esml, d;
    logic [26:0] mx, my0, my, mask, n;
    logic [27:0] sum;
    logic [4:0]  lz;
    logic signed [9:0] e;

    always_comb begin
        sa    = a.sign;
        sb    = b.sign ^ sub;
        a_big = {a.exp, a.frac} >= {b.exp, b.frac};
        ebig  = a_big ? a.exp : b.exp;
        esml  = a_big ? b.exp : a.exp;
        sbig  = a_big ? sa : sb;
        mx    = {1'b1, (a_big ? a.frac : b.frac), 3'b000};
        my0   = {1'b1, (a_big ? b.frac : a.frac), 3'b000};
        d     = ebig - esml;
        mask  = (27'd1 << d) - 27'd1;
        if (d >= 8'd27)
            my = 27'd1;
        else
            my = (my0 >> d) | {26'd0, |(my0 & mask)};
        sum = (sa == sb) ? ({1'b0, mx} + {1'b0, my}) : ({1'b0, mx} - {1'b0, my});
        lz = 5'd0;
        for (int i = 0; i < 27; i++)
            if (sum[i]) lz = 5'(26 - i);
        if (sum[27]) begin
            n = sum[27:1] | {26'd0, sum[0]};
            e = $signed({2'b00, ebig}) + 10'sd1;
        end else begin
            n = sum[26:0] << lz;
            e = $signed({2'b00, ebig}) - $signed({5'd0, lz});
        end

        if (is_nan(a) || is_nan(b))
            y = QNAN;
        else if (is_inf(a) && is_inf(b))
            y = (sa == sb) ? {sa, 8'hFF, 23'd0} : QNAN;
        else if (is_inf(a))
            y = {sa, 8'hFF, 23'd0};
        else if (is_inf(b))
            y = {sb, 8'hFF, 23'd0};
        else if (is_zero(a) && is_zero(b))
            y = {sa & sb, 31'd0};
        else if (is_zero(b))
            y = a;
        else if (is_zero(a))
            y = {sb, b.exp, b.frac};
        else if (sum == 28'd0)
            y = 32'd0;
        else
            y = pack_round(sbig, e, n[26:3], n[2], |n[1:0]);
    end
endmodule

// File: rtl/fpu_mul.sv
module fpu_mul
    import fpu_pkg::*;
(
    input  f32_t a,
    input  f32_t b,
    output f32_t y
);
    logic        s;
    logic [47:0] p;
    logic signed [9:0] e;

    always_comb begin
        s = a.sign ^ b.sign;
        p = {24'd0, 1'b1, a.frac} * {24'd0, 1'b1, b.frac};
        e = $signed({2'b00, a.exp}) + $signed({2'b00, b.exp}) - 10'sd127;
        if (is_nan(a) || is_nan(b))
            y = QNAN;
        else if ((is_inf(a) && is_zero(b)) || (is_inf(b) && is_zero(a)))
            y = QNAN;
        else if (is_inf(a) || is_inf(b))
            y = {s, 8'hFF, 23'd0};
        else if (is_zero(a) || is_zero(b))
            y = {s, 31'd0};
        else if (p[47])
            y = pack_round(s, e + 10'sd1, p[47:24], p[23], |p[22:0]);
        else
            y = pack_round(s, e, p[46:23], p[22], |p[21:0]);
    end
endmodule

// File: rtl/fp_addr_unit.sv
module fp_addr_unit
    import fpu_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int STALL = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    input  logic        wr,
    input  logic        rd,
    output logic [31:0] rdata,
    output logic        ready
);
    localparam int IDX_W = $clog2(NREG);
    localparam int CNT_W = $clog2(STALL + 1);

    logic [NREG-1:0][31:0] regs;
    logic [CNT_W-1:0]      cnt;
    op_e                   op_q;
    logic [IDX_W-1:0]      idx_q;
    f32_t                  opa_q, opb_q;
    f32_t                  sum_y, mul_y, result;
    logic                  commit;
    op_e                   op_in;
    logic [IDX_W-1:0]      idx_in;

    assign op_in  = op_e'(addr[4:3]);
    assign idx_in = addr[IDX_W-1:0];
    assign ready  = (cnt == '0);
    assign commit = (cnt == CNT_W'(1));

    fpu_addsub u_addsub (.a(opa_q), .b(opb_q), .sub(op_q == OP_SUB), .y(sum_y));
    fpu_mul    u_mul    (.a(opa_q), .b(opb_q), .y(mul_y));

    assign result = (op_q == OP_MUL) ? mul_y : sum_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= '0;
            cnt   <= '0;
            rdata <= '0;
            op_q  <= OP_LOAD;
            idx_q <= '0;
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (cnt != '0)
                cnt <= cnt - CNT_W'(1);
            if (commit)
                regs[idx_q] <= result;
            if (ready && wr) begin
                if (op_in == OP_LOAD) begin
                    regs[idx_in] <= wdata;
                end else begin
                    opa_q <= regs[idx_in];
                    opb_q <= wdata;
                    op_q  <= op_in;
                    idx_q <= idx_in;
                    cnt   <= CNT_W'(STALL);
                end
            end
            if (ready && rd)
                rdata <= regs[idx_in];
        end
    end
endmodule

// File: rtl/fp_addr_unit_chk.sv
module fp_addr_unit_chk #(
    parameter int NREG  = 8,
    parameter int STALL = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic [4:0]            addr,
    input logic [31:0]           wdata,
    input logic                  wr,
    input logic                  rd,
    input logic [31:0]           rdata,
    input logic                  ready,
    input logic                  commit,
    input logic [31:0]           result,
    input logic [NREG-1:0][31:0] regs
);
    p_load_raw_r1: assert property (@(posedge clk) disable iff (rst)
        (ready && wr && addr[4:3] == 2'b00) |=> regs[$past(addr[2:0])] == $past(wdata));

    p_stall_start_r9: assert property (@(posedge clk) disable iff (rst)
        (ready && wr && addr[4:3] != 2'b00) |=> !ready);

    p_stall_end_r9: assert property (@(posedge clk) disable iff (rst)
        commit |=> ready);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(ready && rd) |=> $stable(rdata));

    p_nan_canon_r8: assert property (@(posedge clk) disable iff (rst)
        (commit && result[30:23] == 8'hFF && result[22:0] != 23'd0) |-> result == 32'h7FC0_0000);

    p_reset_ready_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ready);

    for (genvar i = 0; i < NREG; i++) begin : g_rst
        p_reset_zero_r11: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> regs[i] == 32'd0);
    end
endmodule

bind fp_addr_unit fp_addr_unit_chk #(.NREG(NREG), .STALL(STALL)) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .ready(ready), .commit(commit), .result(result), .regs(regs)
);

// File: tb/fp_addr_unit_tb.sv
`timescale 1ns/1ps
module fp_addr_unit_tb;
    localparam int STALL = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata;
    logic        ready;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    fp_addr_unit #(.NREG(8), .STALL(STALL)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .ready(ready)
    );

    // Monitor: every accepted read pops one expected word.
    always @(posedge clk) begin
        if (!rst && rd && ready) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL unexpected read: actual %h expected none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        while (!ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic expect_read(input logic [4:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        if (wr) @(negedge clk);
        addr = a; rd = 1'b1;
        while (!ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    // Load register k with a, apply op at address base+k with b, read back.
    task automatic op_check(input logic [2:0] k, input logic [1:0] op,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] e, input string t);
        bus_write({2'b00, k}, a);
        bus_write({op, k}, b);
        expect_read({2'b00, k}, e, t);
    endtask

    task automatic check_stall(input string t);
        int n = 0;
        while (!ready && n < 50) begin n++; @(negedge clk); end
        n_chk++;
        if (n != STALL) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d stall cycles", t, n, STALL);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R11 ready after reset: actual %b expected 1", ready);
        end
        for (int i = 0; i < 8; i++) expect_read(5'(i), 32'h0, "R11 reset zero");

        bus_write(5'd3, 32'h1234_5678);
        expect_read(5'd3, 32'h1234_5678, "R1 raw load");
        bus_write(5'd4, 32'h0000_0001);
        expect_read(5'd4, 32'h0000_0001, "R1 raw subnormal stored");

        op_check(3'd0, 2'b01, 32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, "R2 1+2");
        op_check(3'd1, 2'b10, 32'h4040_0000, 32'h3FC0_0000, 32'h3FC0_0000, "R3 3-1.5");
        op_check(3'd2, 2'b11, 32'h3FC0_0000, 32'h4080_0000, 32'h40C0_0000, "R4 1.5*4");
        op_check(3'd3, 2'b10, 32'h3F80_0000, 32'h4040_0000, 32'hC000_0000, "R3 1-3 negative");
        op_check(3'd4, 2'b11, 32'h3FC0_0000, 32'hBFC0_0000, 32'hC010_0000, "R4 1.5*-1.5");
        op_check(3'd5, 2'b01, 32'h3F80_0001, 32'h3380_0000, 32'h3F80_0002, "R5 tie to even up");
        op_check(3'd6, 2'b01, 32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000, "R5 tie to even down");
        op_check(3'd7, 2'b10, 32'h4000_0000, 32'h4000_0000, 32'h0000_0000, "R12 exact cancel");
        op_check(3'd0, 2'b01, 32'hBF80_0000, 32'h3F80_0000, 32'h0000_0000, "R12 -1+1");
        op_check(3'd1, 2'b01, 32'h3F80_0000, 32'h0000_0001, 32'h3F80_0000, "R6 subnormal input");
        op_check(3'd2, 2'b11, 32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, "R6 flush positive");
        op_check(3'd3, 2'b11, 32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, "R6 flush negative");
        op_check(3'd4, 2'b11, 32'h7F7F_FFFF, 32'h4000_0000, 32'h7F80_0000, "R7 mul overflow");
        op_check(3'd5, 2'b10, 32'hFF7F_FFFF, 32'h7F7F_FFFF, 32'hFF80_0000, "R7 sub overflow");
        op_check(3'd6, 2'b10, 32'h7F80_0000, 32'h7F80_0000, 32'h7FC0_0000, "R8 inf-inf");
        op_check(3'd7, 2'b11, 32'h0000_0000, 32'h7F80_0000, 32'h7FC0_0000, "R8 zero*inf");
        op_check(3'd0, 2'b01, 32'h3F80_0000, 32'h7FC0_0001, 32'h7FC0_0000, "R8 nan operand");
        op_check(3'd1, 2'b01, 32'h7F80_0000, 32'h7F80_0000, 32'h7F80_0000, "R8 inf+inf stays inf");

        // Stall length and a read presented during the stall.
        bus_write(5'd2, 32'h4000_0000);
        bus_write({2'b11, 3'd2}, 32'h4040_0000);
        check_stall("R9 stall length");
        bus_write({2'b01, 3'd2}, 32'h3F80_0000);
        expect_read(5'd2, 32'h40E0_0000, "R9 read waits for result");

        // Accumulate chain into one register; read via aliased addresses.
        bus_write(5'd5, 32'h3F80_0000);
        bus_write({2'b01, 3'd5}, 32'h3F80_0000);
        bus_write({2'b11, 3'd5}, 32'h4040_0000);
        bus_write({2'b10, 3'd5}, 32'h3F80_0000);
        expect_read({2'b01, 3'd5}, 32'h40A0_0000, "R10 alias read 13");
        expect_read({2'b11, 3'd5}, 32'h40A0_0000, "R10 alias read 29");
        expect_read({2'b10, 3'd2}, 32'h40E0_0000, "R10 alias read 18");

        // rdata must hold with no accepted read.
        repeat (3) @(negedge clk);
        n_chk++;
        if (rdata !== 32'h40E0_0000) begin
            n_bad++;
            $display("FAIL R10 rdata hold: actual %h expected %h", rdata, 32'h40E0_0000);
        end

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL pending reads: actual %0d expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule